// File: doc/BRIEF.md
# Interrupt Concentrator with Mapping Registers

The concentrator collects sixty-four level-sensitive interrupt lines and turns them into a single outstanding request. Lines 0 to 31 belong to expansion-slot sources and are grouped four to a routing entry. Lines 32 to 63 belong to on-board devices and each has a routing entry of its own. Every routing entry carries an enable flag in bit 31. The lower bits of each entry are a fixed routing tag that software can read but cannot change.

At most one request is pending at any time. It appears as a single high wire on a 64-wire vector whose index is the source number. That wire stays high until software releases it through one of two clear windows. Slot clears work per group of four lines, and on-board clears work per line. Each write to a routing entry, and each release that matches, starts a scan. The scan keeps a request that has not yet been acknowledged. Otherwise it picks the lowest-numbered active line that is enabled.

Software uses a 32-bit register bus with a write strobe and combinational read data. All live registers sit in the upper word of an 8-byte slot (address bit 2 set). A scan takes one cycle, so the vector changes on the clock edge that samples the triggering write or input edge.

Top module: `irq_concentrator`

## Requirements
- R1: After reset the vector output is all zero and every routing entry reads with bit 31 clear. Slot entry g reads 0x7C0 | (g*4) and on-board entry n reads 0x7E0 + n in bits 30:0. Reset also clears the pending request and the latched input levels.
- R2: Writing the upper word of a routing entry changes only bit 31; bits 30:0 keep their fixed tag. Slot entry g is at 0x0C04 + 8*g and on-board entry n is at 0x1004 + 8*n.
- R3: A bus access with address bit 2 clear reads zero and changes no state.
- R4: At most one vector wire is high, and its index equals the pending source number.
- R5: A rising slot line (0 to 31) whose group entry g = line/4 is enabled takes the request on the next edge, even if another request is pending.
- R6: A rising on-board line whose entry is enabled takes the request only when no request is pending.
- R7: A pending request stays asserted after its input line falls, until software releases it.
- R8: Writing 0 to bit 31 of the entry that routes the pending source drops that request and starts a scan in the same cycle.
- R9: A write to slot clear n at 0x1404 + 32*n releases the pending request only if request/4 equals n; a write to any other n has no effect.
- R10: A write to on-board clear n at 0x1804 + 8*n releases the pending request only if it equals 32 + n.
- R11: A scan with nothing pending selects the lowest-numbered active enabled line, and it checks lines 0 to 31 before lines 32 to 63.
- R12: Every routing write starts a scan. If a request is still pending, the scan keeps it, and an enabled line that is already high is picked up without a new edge.
- R13: A line whose routing entry is disabled never becomes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 64 | Level interrupt lines; 0–31 slot, 32–63 on-board |
| busAddr | input | 16 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data; only bit 31 is used by routing writes |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqVecOut | output | 64 | One-hot pending request vector |

## Verification
The checker takes for granted that each write strobe lasts one cycle and that interrupt lines change only between clock edges. On that basis it assumes the vector can move only because of a bus write or a rising line. The stimulus changes inputs and the bus only on the falling edge and holds each write for exactly one cycle. It keeps a write and a rising line together only in steps where the expected index already accounts for both. Reads happen with the strobe low, so every read check observes state without disturbing it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_PCI_LINES = 32;
  localparam int LINES_PER_MAP = 4;
  localparam int NUM_OB_LINES  = 32;
  localparam int ADDR_W        = 16;
  localparam int DATA_W        = 32;

  localparam int NUM_PCI_MAPS = NUM_PCI_LINES / LINES_PER_MAP;
  localparam int NUM_MAPS     = NUM_PCI_MAPS + NUM_OB_LINES;
  localparam int NUM_SRC      = NUM_PCI_LINES + NUM_OB_LINES;
  localparam int SRC_W        = $clog2(NUM_SRC) + 1;
  localparam int MAP_W        = $clog2(NUM_MAPS);
  localparam int GRP_W        = $clog2(NUM_PCI_MAPS);
  localparam int OB_W         = $clog2(NUM_OB_LINES);
  localparam int ENABLE_BIT   = 31;

  // index one past the last source marks "no request pending"
  localparam logic [SRC_W-1:0] SRC_NONE = SRC_W'(NUM_SRC);

  localparam int MAP_STRIDE_LOG    = 3;
  localparam int PCI_CLR_STRIDE_LOG = 5;
  localparam int OB_CLR_STRIDE_LOG  = 3;

  localparam logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00;
  localparam logic [ADDR_W-1:0] OB_MAP_BASE  = 16'h1000;
  localparam logic [ADDR_W-1:0] PCI_CLR_BASE = 16'h1400;
  localparam logic [ADDR_W-1:0] OB_CLR_BASE  = 16'h1800;

  localparam logic [10:0] ROUTE_TAG  = 11'h7C0;
  localparam logic [10:0] OB_TAG_OFS = 11'h020;

  typedef struct packed {
    logic             mapWr;
    logic [MAP_W-1:0] mapIdx;
    logic             mapEn;
    logic             pciClr;
    logic [GRP_W-1:0] pciGrp;
    logic             obClr;
    logic [OB_W-1:0]  obIdx;
  } ctrlStrobeT;

  function automatic logic [30:0] mapLowBits(input logic [MAP_W-1:0] idx);
    if (int'(idx) < NUM_PCI_MAPS)
      return 31'(ROUTE_TAG) | 31'(int'(idx) * LINES_PER_MAP);
    return 31'(ROUTE_TAG) + 31'(OB_TAG_OFS) + 31'(int'(idx) - NUM_PCI_MAPS);
  endfunction

  function automatic logic [MAP_W-1:0] srcToMap(input logic [SRC_W-1:0] src);
    if (int'(src) < NUM_PCI_LINES)
      return MAP_W'(int'(src) / LINES_PER_MAP);
    return MAP_W'(int'(src) - NUM_PCI_LINES + NUM_PCI_MAPS);
  endfunction
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [NUM_MAPS-1:0] mapEnable,
  output ctrlStrobeT          strobe,
  output logic [DATA_W-1:0]   busRdData
);
  localparam logic [ADDR_W-1:0] PCI_MAP_SPAN = ADDR_W'(NUM_PCI_MAPS << MAP_STRIDE_LOG);
  localparam logic [ADDR_W-1:0] OB_MAP_SPAN  = ADDR_W'(NUM_OB_LINES << MAP_STRIDE_LOG);
  localparam logic [ADDR_W-1:0] PCI_CLR_SPAN = ADDR_W'(NUM_PCI_MAPS << PCI_CLR_STRIDE_LOG);
  localparam logic [ADDR_W-1:0] OB_CLR_SPAN  = ADDR_W'(NUM_OB_LINES << OB_CLR_STRIDE_LOG);

  logic [ADDR_W-1:0] pciMapOfs, obMapOfs, pciClrOfs, obClrOfs;
  logic hitPciMap, hitObMap, hitPciClr, hitObClr, upperWord, liveWr;
  logic [MAP_W-1:0] mapFlat;
  logic unusedDataBits;

  assign pciMapOfs = busAddr - PCI_MAP_BASE;
  assign obMapOfs  = busAddr - OB_MAP_BASE;
  assign pciClrOfs = busAddr - PCI_CLR_BASE;
  assign obClrOfs  = busAddr - OB_CLR_BASE;

  assign hitPciMap = pciMapOfs < PCI_MAP_SPAN;
  assign hitObMap  = obMapOfs  < OB_MAP_SPAN;
  assign hitPciClr = pciClrOfs < PCI_CLR_SPAN;
  assign hitObClr  = obClrOfs  < OB_CLR_SPAN;
  assign upperWord = busAddr[2];
  assign liveWr    = busWrEn & upperWord;

  assign mapFlat = hitPciMap ? MAP_W'(pciMapOfs[MAP_STRIDE_LOG +: GRP_W])
                             : MAP_W'(NUM_PCI_MAPS) + MAP_W'(obMapOfs[MAP_STRIDE_LOG +: OB_W]);

  always_comb begin
    strobe        = '0;
    strobe.mapWr  = liveWr & (hitPciMap | hitObMap);
    strobe.mapIdx = mapFlat;
    strobe.mapEn  = busWrData[ENABLE_BIT];
    strobe.pciClr = liveWr & hitPciClr;
    strobe.pciGrp = pciClrOfs[PCI_CLR_STRIDE_LOG +: GRP_W];
    strobe.obClr  = liveWr & hitObClr;
    strobe.obIdx  = obClrOfs[OB_CLR_STRIDE_LOG +: OB_W];
  end

  always_comb begin
    busRdData = '0;
    if (upperWord && (hitPciMap || hitObMap))
      busRdData = {mapEnable[mapFlat], mapLowBits(mapFlat)};
  end

  assign unusedDataBits = ^busWrData[ENABLE_BIT-1:0];
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  irqIn,
  input  ctrlStrobeT          strobe,
  output logic [NUM_MAPS-1:0] mapEnable,
  output logic [SRC_W-1:0]    pendIdx
);
  localparam logic [NUM_SRC-1:0] PCI_MASK =
    {{NUM_OB_LINES{1'b0}}, {NUM_PCI_LINES{1'b1}}};

  logic [NUM_MAPS-1:0] mapEnQ, mapEnNext;
  logic [NUM_SRC-1:0]  levelQ, srcEnabled, riseVec, activeEn, pciRiseEn, obRiseEn;
  logic [SRC_W-1:0]    pendQ, curIdx;
  logic                rescan;

  function automatic logic [SRC_W-1:0] lowestSet(input logic [NUM_SRC-1:0] vec);
    lowestSet = SRC_NONE;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (vec[k]) lowestSet = SRC_W'(k);
  endfunction

  always_comb begin
    mapEnNext = mapEnQ;
    if (strobe.mapWr) mapEnNext[strobe.mapIdx] = strobe.mapEn;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_route
    assign srcEnabled[k] = mapEnNext[srcToMap(SRC_W'(k))];
  end

  assign riseVec   = irqIn & ~levelQ;
  assign activeEn  = irqIn & srcEnabled;
  assign pciRiseEn = riseVec & srcEnabled & PCI_MASK;
  assign obRiseEn  = riseVec & srcEnabled & ~PCI_MASK;

  always_comb begin
    curIdx = pendQ;
    rescan = 1'b0;
    if (strobe.mapWr) begin
      rescan = 1'b1;
      if (!strobe.mapEn && curIdx != SRC_NONE && srcToMap(curIdx) == strobe.mapIdx)
        curIdx = SRC_NONE;
    end
    if (strobe.pciClr && int'(curIdx) < NUM_PCI_LINES &&
        int'(curIdx) / LINES_PER_MAP == int'(strobe.pciGrp)) begin
      curIdx = SRC_NONE;
      rescan = 1'b1;
    end
    if (strobe.obClr && curIdx == SRC_W'(NUM_PCI_LINES + int'(strobe.obIdx))) begin
      curIdx = SRC_NONE;
      rescan = 1'b1;
    end
    if (rescan && curIdx == SRC_NONE)
      curIdx = lowestSet(activeEn);
    if (|pciRiseEn)
      curIdx = lowestSet(pciRiseEn);
    else if (|obRiseEn && curIdx == SRC_NONE)
      curIdx = lowestSet(obRiseEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapEnQ <= '0;
      levelQ <= '0;
      pendQ  <= SRC_NONE;
    end else begin
      mapEnQ <= mapEnNext;
      levelQ <= irqIn;
      pendQ  <= curIdx;
    end
  end

  assign mapEnable = mapEnQ;
  assign pendIdx   = pendQ;
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_SRC-1:0] irqVecOut
);
  ctrlStrobeT          strobe;
  logic [NUM_MAPS-1:0] mapEnable;
  logic [SRC_W-1:0]    pendIdx;

  irqc_ctrl ctrl_i (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .mapEnable (mapEnable),
    .strobe    (strobe),
    .busRdData (busRdData)
  );

  irqc_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .strobe    (strobe),
    .mapEnable (mapEnable),
    .pendIdx   (pendIdx)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_vec
    assign irqVecOut[k] = (pendIdx == SRC_W'(k));
  end
endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk
  import irqc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busRdData,
  input logic [NUM_SRC-1:0] irqVecOut
);
  logic [NUM_SRC-1:0] prevIn, riseAll;
  logic               pciUpperRd;
  logic [30:0]        pciTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= irqIn;
  end

  assign riseAll    = irqIn & ~prevIn;
  assign pciUpperRd = (busAddr >= 16'h0C00) && (busAddr < 16'h0C40) && busAddr[2];
  assign pciTag     = 31'h7C0 | (31'(busAddr[5:3]) << 2);

  assert_onehot_vec_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqVecOut));

  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqVecOut != '0 && !busWrEn && riseAll[NUM_PCI_LINES-1:0] == '0)
      |=> $stable(irqVecOut));

  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rstN)
    (irqVecOut == '0 && !busWrEn && riseAll == '0) |=> (irqVecOut == '0));

  assert_lower_word_inert_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busAddr[2] && riseAll == '0) |=> $stable(irqVecOut));

  assert_fixed_tag_R2: assert property (@(posedge clk) disable iff (!rstN)
    pciUpperRd |-> (busRdData[30:0] == pciTag));
endmodule

bind irq_concentrator irq_concentrator_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .irqVecOut (irqVecOut)
);

// File: tb/irq_concentrator_tb_top.sv
module irq_concentrator_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] irqVecOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_concentrator dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqVecOut(irqVecOut)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic [63:0] irq;
    logic [6:0]  expIdx;
    logic [3:0]  tag;
  } stepT;

  localparam int NSTEPS = 27;
  localparam stepT STEPS [NSTEPS] = '{
    '{1'b1, 16'h0C04, 32'h8000_0000, 64'h0,                    7'd64, 4'd2 },  // R2 enable group 0
    '{1'b0, 16'h0000, 32'h0,         64'h2,                    7'd1,  4'd5 },  // R5 slot line 1 rises
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0002,  7'd1,  4'd13},  // R13 line 40 disabled
    '{1'b1, 16'h1044, 32'h8000_0000, 64'h0000_0100_0000_0002,  7'd1,  4'd12},  // R12 rescan keeps pending
    '{1'b1, 16'h1404, 32'h0,         64'h0000_0100_0000_0002,  7'd1,  4'd9 },  // R9 clear grp0, 1 still high
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0000,  7'd1,  4'd7 },  // R7 held after line drops
    '{1'b1, 16'h1424, 32'h0,         64'h0000_0100_0000_0000,  7'd1,  4'd9 },  // R9 wrong group ignored
    '{1'b1, 16'h1404, 32'h0,         64'h0000_0100_0000_0000,  7'd40, 4'd11},  // R11 rescan finds 40
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0020,  7'd40, 4'd13},  // R13 line 5 disabled
    '{1'b1, 16'h0C0C, 32'h8000_0000, 64'h0000_0100_0000_0020,  7'd40, 4'd12},  // R12 enable grp1, 40 kept
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0060,  7'd6,  4'd5 },  // R5 slot 6 overrides
    '{1'b1, 16'h1844, 32'h0,         64'h0000_0100_0000_0060,  7'd6,  4'd10},  // R10 ob clear 8 != 6
    '{1'b1, 16'h0C0C, 32'h0,         64'h0000_0100_0000_0060,  7'd40, 4'd8 },  // R8 disable grp1 drops 6
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0102_0000_0060,  7'd40, 4'd13},  // R13 line 33 disabled
    '{1'b1, 16'h100C, 32'h8000_0000, 64'h0000_0102_0000_0060,  7'd40, 4'd12},  // R12 enable ob1
    '{1'b1, 16'h1844, 32'h0,         64'h0000_0102_0000_0060,  7'd33, 4'd11},  // R11 lowest on-board
    '{1'b1, 16'h104C, 32'h8000_0000, 64'h0000_0102_0000_0060,  7'd33, 4'd2 },  // R2 enable ob9
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0302_0000_0060,  7'd33, 4'd6 },  // R6 ob rise while pending
    '{1'b1, 16'h180C, 32'h0,         64'h0000_0300_0000_0060,  7'd40, 4'd10},  // R10 ob clear 1 matches
    '{1'b1, 16'h0C08, 32'h8000_0000, 64'h0000_0300_0000_00E0,  7'd40, 4'd3 },  // R3 lower word write
    '{1'b1, 16'h1844, 32'h0,         64'h0000_0200_0000_00E0,  7'd41, 4'd3 },  // R3 line 7 still disabled
    '{1'b1, 16'h184C, 32'h0,         64'h0,                    7'd64, 4'd10},  // R10 clear 9, nothing left
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0000,  7'd40, 4'd6 },  // R6 ob rise, none pending
    '{1'b0, 16'h0000, 32'h0,         64'h0000_0100_0000_0001,  7'd0,  4'd5 },  // R5 slot 0 overrides 40
    '{1'b1, 16'h0C04, 32'h0,         64'h0000_0100_0000_0001,  7'd40, 4'd8 },  // R8 disable grp0 drops 0
    '{1'b1, 16'h0C04, 32'h8000_0000, 64'h0000_0100_0000_0001,  7'd40, 4'd12},  // R12 pending kept
    '{1'b1, 16'h1844, 32'h0,         64'h0000_0100_0000_0001,  7'd0,  4'd11}   // R11 slot before on-board
  };

  task automatic checkVec(input logic [6:0] expIdx, input int tag);
    logic [63:0] expVec;
    expVec = (expIdx == 7'd64) ? 64'h0 : (64'h1 << expIdx);
    checks++;
    if (irqVecOut !== expVec) begin
      errors++;
      $display("FAIL R%0d: irqVecOut=%h expected %h", tag, irqVecOut, expVec);
    end
  endtask

  task automatic runStep(input logic wr, input logic [15:0] addr, input logic [31:0] data,
                         input logic [63:0] irq, input logic [6:0] expIdx, input int tag);
    @(negedge clk);
    busWrEn = wr; busAddr = addr; busWrData = data; irqIn = irq;
    @(negedge clk);
    busWrEn = 1'b0;
    checkVec(expIdx, tag);
  endtask

  task automatic checkRd(input logic [15:0] addr, input logic [31:0] expVal, input int tag);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = addr;
    #1;
    checks++;
    if (busRdData !== expVal) begin
      errors++;
      $display("FAIL R%0d: read %h gave %h expected %h", tag, addr, busRdData, expVal);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVec(7'd64, 1);                          // R1 output idle in reset
    checkRd(16'h0C04, 32'h0000_07C0, 1);         // R1 slot entry 0 default
    checkRd(16'h10FC, 32'h0000_07FF, 1);         // R1 on-board entry 31 default
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NSTEPS; i++)
      runStep(STEPS[i].wr, STEPS[i].addr, STEPS[i].data, STEPS[i].irq,
              STEPS[i].expIdx, int'(STEPS[i].tag));

    checkRd(16'h0C04, 32'h8000_07C0, 2);         // R2 enabled group 0
    checkRd(16'h0C0C, 32'h0000_07C4, 2);         // R2 group 1 disabled again
    checkRd(16'h0C08, 32'h0000_0000, 3);         // R3 lower word reads zero
    checkRd(16'h1044, 32'h8000_07E8, 2);         // R2 on-board 8
    checkRd(16'h1004, 32'h0000_07E0, 2);         // R2 on-board 0 untouched
    runStep(1'b1, 16'h0C14, 32'hFFFF_FFFF, 64'h0000_0100_0000_0001, 7'd0, 2); // R2
    checkRd(16'h0C14, 32'h8000_07C8, 2);         // R2 tag bits kept

    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    checkVec(7'd64, 1);                          // R1 pending cleared
    checkRd(16'h0C04, 32'h0000_07C0, 1);         // R1 enable cleared
    checkRd(16'h0C14, 32'h0000_07C8, 1);         // R1 tag kept
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkVec(7'd64, 13);                         // R13 high lines stay masked
    checkRd(16'h0C00, 32'h0, 3);                 // R3

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule